// File: doc/BRIEF.md
# Segment Polarity Command Unpacker

This block takes the bytes of a variable-length polarity command and turns them into a register of per-segment reversal bits. The opening byte holds a command code and three segment bits. Each byte after it holds seven more. Bit 7 of every byte says whether another byte follows. Segment 1 sits at the most significant segment bit of the opening byte, and numbering runs downward through each byte in turn. Bits for segments beyond the implemented count are dropped. Extra bytes are dropped too.

The new segment values are built in a shadow register and written to the visible register in one step, when the final byte arrives. The block then raises `done` and holds it until the surrounding logic acknowledges that the reply went out. While a command is being collected or waiting for that acknowledgement, the block is busy. A new command that starts during that time is flagged as a protocol error and ignored. A power-on event returns every segment to the unreversed state.

Top module: `seg_polarity_unpacker`

## Requirements
- R1: After reset, `seg_reverse` is all zero, and `done`, `busy` and `proto_err` are low.
- R2: While idle, an accepted byte with bit 7 = 1 and bits 6:3 = 4'b0010 starts a command. Its bits 2, 1 and 0 give segments 1, 2 and 3, which are `seg_reverse[0]`, `[1]` and `[2]`.
- R3: Each later byte in the command supplies the next seven segments from its bits 6 down to 0. Segment n always appears at `seg_reverse[n-1]`.
- R4: A later byte with bit 7 = 0 ends the command. `seg_reverse` takes all of its new bits in the cycle after that byte is accepted, and it does not change while earlier bytes are being collected.
- R5: Bits for segments numbered above NSEG have no effect on `seg_reverse`. Bytes after the last one needed also have no effect.
- R6: A segment that the command carries no bit for becomes 0 when the command completes.
- R7: `done` is high from the cycle after the final byte until the cycle after `reply_ack` is sampled high.
- R8: `busy` is high from the cycle after the opening byte until the cycle after `reply_ack` ends the wait.
- R9: `proto_err` pulses high for one cycle after either of these bytes: a byte with bits 6:3 = 4'b0010 and bit 7 = 0 while idle, or any byte with bits 6:3 = 4'b0010 while waiting for `reply_ack`. The offending byte changes neither `seg_reverse` nor `busy`.
- R10: A `power_on` pulse clears every bit of `seg_reverse` in the next cycle. It wins over a command completing in the same cycle.
- R11: While idle, a byte whose bits 6:3 are not 4'b0010 is ignored. `busy`, `proto_err` and `seg_reverse` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_valid | input | 1 | A command byte is presented this cycle |
| byte_data | input | 8 | Command byte; bit 7 is the continuation flag |
| reply_ack | input | 1 | Completion reply has been sent; ends the wait |
| power_on | input | 1 | Power-on event; clears all segments |
| seg_reverse | output | NSEG | Reversal bit per segment; bit n-1 is segment n |
| done | output | 1 | Command applied, reply pending |
| busy | output | 1 | Command in progress or awaiting acknowledgement |
| proto_err | output | 1 | One-cycle protocol error pulse |

## Verification
If the byte counter is wrong, bits land in the wrong segment positions, and that shows at `seg_reverse` one cycle after the final byte. A shadow register that fails to clear leaves old bits behind, and that appears as soon as a short command follows a full one. A state machine that leaves the waiting state too early shows up as a missing `proto_err` or an early fall of `done` in the cycle after the offending input. A missing power-on clear can be seen one cycle after the pulse.

// File: rtl/seg_pol_pkg.sv
package seg_pol_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_COLLECT = 2'd1,
      ST_PENDING = 2'd2
   } pol_state_e;

   localparam logic [3:0] POL_CMD_CODE = 4'b0010;
   localparam int         HEAD_BITS    = 3;
   localparam int         TAIL_BITS    = 7;
endpackage

// File: rtl/pol_seq_ctrl.sv
module pol_seq_ctrl
   import seg_pol_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       byte_valid,
   input  logic [7:3] byte_hi,
   input  logic       reply_ack,
   output logic       start,
   output logic       take,
   output logic       commit,
   output logic       busy,
   output logic       done,
   output logic       proto_err
);
   pol_state_e state_q, state_d;
   logic       is_pol;
   logic       bad;
   logic       err_q;

   assign is_pol = (byte_hi[6:3] == POL_CMD_CODE);
   assign start  = byte_valid && (state_q == ST_IDLE) && is_pol && byte_hi[7];
   assign take   = byte_valid && (state_q == ST_COLLECT);
   assign commit = take && !byte_hi[7];
   assign bad    = byte_valid && is_pol &&
                   (((state_q == ST_IDLE) && !byte_hi[7]) || (state_q == ST_PENDING));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (start)     state_d = ST_COLLECT;
         ST_COLLECT: if (commit)    state_d = ST_PENDING;
         ST_PENDING: if (reply_ack) state_d = ST_IDLE;
         default:                   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         err_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         err_q   <= bad;
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_PENDING);
   assign proto_err = err_q;

   // R7
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> done);
   // R7
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !reply_ack) |=> done);
   // R8
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && !done));
   // R9
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (proto_err && !bad) |=> !proto_err);
   // R9
   err_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && is_pol && !byte_hi[7] && !busy) |=> (proto_err && !busy));
endmodule

// File: rtl/pol_bit_packer.sv
module pol_bit_packer
   import seg_pol_pkg::*;
#(
   parameter int NSEG = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            take,
   input  logic [6:0]      byte_lo,
   output logic [NSEG-1:0] shadow_nxt
);
   localparam int LAST_BYTE = (NSEG <= HEAD_BITS) ? 0 :
                              ((NSEG - HEAD_BITS - 1) / TAIL_BITS + 1);
   localparam int CNT_MAX   = LAST_BYTE + 1;
   localparam int CW        = $clog2(CNT_MAX + 1);

   logic [NSEG-1:0] shadow_q;
   logic [CW-1:0]   cnt_q;

   for (genvar i = 0; i < NSEG; i++) begin : g_seg
      localparam int BYTE_NO = (i < HEAD_BITS) ? 0 : ((i - HEAD_BITS) / TAIL_BITS + 1);
      localparam int BIT_POS = (i < HEAD_BITS) ? (HEAD_BITS - 1 - i) :
                               (TAIL_BITS - 1 - ((i - HEAD_BITS) % TAIL_BITS));
      logic bit_n;
      if (BYTE_NO == 0) begin : g_head
         always_comb begin
            bit_n = shadow_q[i];
            if (start) bit_n = byte_lo[BIT_POS];
         end
      end else begin : g_tail
         always_comb begin
            bit_n = shadow_q[i];
            if (start)
               bit_n = 1'b0;
            else if (take && (cnt_q == CW'(BYTE_NO)))
               bit_n = byte_lo[BIT_POS];
         end
      end
      assign shadow_nxt[i] = bit_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         cnt_q    <= '0;
      end else begin
         shadow_q <= shadow_nxt;
         if (start)
            cnt_q <= CW'(1);
         else if (take && (cnt_q != CW'(CNT_MAX)))
            cnt_q <= cnt_q + CW'(1);
      end
   end

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(CNT_MAX));
   // R3
   cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt_q == CW'(1)));
endmodule

// File: rtl/pol_seg_store.sv
module pol_seg_store #(
   parameter int NSEG = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            power_on,
   input  logic            commit,
   input  logic [NSEG-1:0] shadow_nxt,
   output logic [NSEG-1:0] seg_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        seg_q <= '0;
      else if (power_on) seg_q <= '0;
      else if (commit)   seg_q <= shadow_nxt;
   end

   // R10
   pwr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      power_on |=> (seg_q == '0));
   // R4
   seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!power_on && !commit) |=> $stable(seg_q));
   // R4
   seg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !power_on) |=> (seg_q == $past(shadow_nxt)));
endmodule

// File: rtl/seg_polarity_unpacker.sv
module seg_polarity_unpacker #(
   parameter int NSEG = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            byte_valid,
   input  logic [7:0]      byte_data,
   input  logic            reply_ack,
   input  logic            power_on,
   output logic [NSEG-1:0] seg_reverse,
   output logic            done,
   output logic            busy,
   output logic            proto_err
);
   if (NSEG < 1 || NSEG > 256) begin : g_bad_nseg
      $error("seg_polarity_unpacker: NSEG out of range 1..256");
   end

   logic start, take, commit;
   logic [NSEG-1:0] shadow_nxt;

   pol_seq_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_valid (byte_valid),
      .byte_hi    (byte_data[7:3]),
      .reply_ack  (reply_ack),
      .start      (start),
      .take       (take),
      .commit     (commit),
      .busy       (busy),
      .done       (done),
      .proto_err  (proto_err)
   );

   pol_bit_packer #(.NSEG(NSEG)) u_pack (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .take       (take),
      .byte_lo    (byte_data[6:0]),
      .shadow_nxt (shadow_nxt)
   );

   pol_seg_store #(.NSEG(NSEG)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .power_on   (power_on),
      .commit     (commit),
      .shadow_nxt (shadow_nxt),
      .seg_q      (seg_reverse)
   );

   // R8
   busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
endmodule

// File: tb/tb_seg_polarity_unpacker.sv
`timescale 1ns/1ps
module tb_seg_polarity_unpacker;
   localparam int NSEG = 14;
   localparam int NV   = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            byte_valid = 1'b0;
   logic [7:0]      byte_data = 8'h00;
   logic            reply_ack = 1'b0;
   logic            power_on = 1'b0;
   logic [NSEG-1:0] seg_reverse;
   logic            done, busy, proto_err;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   seg_polarity_unpacker #(.NSEG(NSEG)) dut (
      .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_data(byte_data),
      .reply_ack(reply_ack), .power_on(power_on), .seg_reverse(seg_reverse),
      .done(done), .busy(busy), .proto_err(proto_err)
   );

   // command bytes, byte count, expected seg_reverse (bit n-1 = segment n)
   localparam logic [7:0] VB [NV][4] = '{
      '{8'h90, 8'h88, 8'h7A, 8'h00},   // R3 segments 7 and 11..14
      '{8'h97, 8'hFF, 8'h7F, 8'h00},   // R2 R3 all set
      '{8'h92, 8'h01, 8'h00, 8'h00},   // R6 short command
      '{8'h90, 8'h80, 8'h00, 8'h00},   // all clear
      '{8'h94, 8'h80, 8'h00, 8'h00},   // R2 segment 1
      '{8'h91, 8'hC0, 8'h00, 8'h00},   // R2 R3 segments 3 and 4
      '{8'h90, 8'h80, 8'h81, 8'h7F},   // R5 surplus bit and extra byte
      '{8'h90, 8'h80, 8'h40, 8'h00}    // R3 segment 11
   };
   localparam int VL [NV] = '{3, 3, 2, 3, 3, 3, 4, 3};
   localparam logic [NSEG-1:0] VE [NV] = '{
      14'h3C40, 14'h3FFF, 14'h0202, 14'h0000,
      14'h0001, 14'h000C, 14'h0000, 14'h0400
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [7:0] b, input logic pwr);
      @(negedge clk);
      byte_valid = 1'b1;
      byte_data  = b;
      power_on   = pwr;
      @(negedge clk);
      byte_valid = 1'b0;
      power_on   = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk);
      reply_ack = 1'b1;
      @(negedge clk);
      reply_ack = 1'b0;
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 seg", int'(seg_reverse), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 busy", int'(busy), 0);
      chk("R1 err", int'(proto_err), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         for (int k = 0; k < VL[v]; k++) send(VB[v][k], 1'b0);
         chk("R3 R4 R5 R6 vector seg", int'(seg_reverse), int'(VE[v]));
         chk("R7 done after final", int'(done), 1);
         ack();
         chk("R7 R8 released", int'({done, busy}), 0);
      end

      // R4 atomic update; R8 busy while collecting
      send(8'h97, 1'b0);
      send(8'hFF, 1'b0);
      chk("R4 held during collect", int'(seg_reverse), 'h0400);
      chk("R8 busy collect", int'({busy, done}), 2);
      send(8'h7F, 1'b0);
      chk("R4 applied", int'(seg_reverse), 'h3FFF);

      // R9 new command while awaiting reply
      send(8'h90, 1'b0);
      chk("R9 pending err", int'(proto_err), 1);
      chk("R9 seg kept", int'(seg_reverse), 'h3FFF);
      chk("R7 still done", int'(done), 1);
      @(negedge clk);
      chk("R9 one pulse", int'(proto_err), 0);
      ack();

      // R9 first byte with bit 7 clear
      send(8'h15, 1'b0);
      chk("R9 bit7 clear err", int'(proto_err), 1);
      chk("R9 not busy", int'(busy), 0);

      // R11 foreign byte then a stray continuation
      send(8'hA5, 1'b0);
      chk("R11 no err", int'({proto_err, busy}), 0);
      send(8'h7F, 1'b0);
      chk("R11 idle", int'({proto_err, busy}), 0);
      chk("R11 seg kept", int'(seg_reverse), 'h3FFF);

      // R10 power-on clears
      @(negedge clk);
      power_on = 1'b1;
      @(negedge clk);
      power_on = 1'b0;
      chk("R10 clear", int'(seg_reverse), 0);

      // R10 precedence over same-cycle commit
      send(8'h97, 1'b0);
      send(8'hFF, 1'b0);
      send(8'h7F, 1'b1);
      chk("R10 precedence seg", int'(seg_reverse), 0);
      chk("R10 done still", int'(done), 1);
      ack();
      chk("R7 done released", int'(done), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule